// File: doc/BRIEF.md
# Register-Programmed Pulse-Width Modulator

This block generates one pulse-width modulated output from three registers that software writes over a simple synchronous bus. One register holds a duty count and one holds a period count. A control word sets run or stop, polarity, single-pulse operation, the output-enable pin, a counter restart and an end-of-period interrupt. An internal counter advances once per clock. The output level is found by comparing the counter with the duty count.

Any change to the duty or period takes effect on the next clock edge. The counter restarts from zero at that point and the period that was running is dropped. Stopping the block forces the output low at once. A period-end flag can drive a level interrupt, and software clears the flag by writing 1 to it.

Top module: `regpwm`

## Requirements
- R1: Word offset 0x4 holds the duty count, 0x8 holds the period count and 0xC holds the control word. All three read back on `rd_data`, and any other offset reads 0. After reset every register and the counter are 0, `pwm_o` is 0, `pwm_oe_o` is 1 and `irq_o` is 0.
- R2: While control bit 0 (run) is 1 and the period P is nonzero, the counter steps through 0 to P-1 one per clock and then returns to 0. With control bit 9 at 0, `pwm_o` is 1 while the count is below the duty D, so each period has D high cycles. If D is P or more, the output stays high.
- R3: With control bit 9 at 1, the output is inverted: low while the count is below D and high for the rest of the period.
- R4: When D and P are both 0, `pwm_o` stays 0 for either polarity.
- R5: While run is 0, `pwm_o` is 0 for either polarity. Writing run as 0 forces the output low from the next cycle and holds the counter. Writing run as 1 again resumes counting from the held value.
- R6: A write to the duty or period register sets the counter to 0 on that edge. The new value is used from the next cycle.
- R7: Each counter wrap sets control bit 6 (flag). `irq_o` is the flag ANDed with control bit 5 (interrupt enable). Writing 1 to bit 6 clears the flag, and writing 0 leaves it unchanged. A wrap on the same edge as a clearing write leaves the flag set.
- R8: With control bit 4 (single pulse) at 1, the wrap at the end of a period clears run. The output then stays 0 and the counter stays at 0.
- R9: Writing 1 to control bit 7 sets the counter to 0. Bit 7 always reads 0. Bits 0, 3, 4, 5 and 9 read back as written, and all undefined bits read 0.
- R10: `pwm_oe_o` is the inverse of control bit 3, so the pin is driven only while that bit is 0.
- R11: When P is 0 and D is nonzero while running, the counter stays at 0, the output holds its active level and the flag is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW (4) | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe for `wr_data` at `addr` |
| wr_data | input | W (32) | Write data |
| rd_data | output | W (32) | Combinational read data for `addr` |
| pwm_o | output | 1 | Modulated output |
| pwm_oe_o | output | 1 | Pin drive enable, high when the pin should drive |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach is a period boundary that lands on the same edge as a register write. A flag clear that meets a wrap, or a restart that falls in the middle of a period, only happens when the write is placed at one exact count. The stimulus writes while the counter is free-running at many different phases, and also issues single-pulse and restart writes at fixed offsets. A behavioural model in the bench follows every write and wrap and is compared with the outputs and the read data on every clock, so each of these collisions is checked whenever it occurs.

// File: rtl/regpwm.sv
module regpwm #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          pwm_o,
  output logic          pwm_oe_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] A_DUTY = AW'(4);
  localparam logic [AW-1:0] A_PER  = AW'(8);
  localparam logic [AW-1:0] A_CTL  = AW'(12);
  localparam int B_RUN = 0;
  localparam int B_HIZ = 3;
  localparam int B_ONE = 4;
  localparam int B_IEN = 5;
  localparam int B_FLG = 6;
  localparam int B_CLR = 7;
  localparam int B_INV = 9;

  logic [W-1:0] duty_q, per_q, cnt_q;
  logic run_q, hiz_q, one_q, ien_q, flag_q, inv_q;

  wire wr_duty  = wr_en && (addr == A_DUTY);
  wire wr_per   = wr_en && (addr == A_PER);
  wire wr_ctl   = wr_en && (addr == A_CTL);
  wire restart  = wr_duty || wr_per || (wr_ctl && wr_data[B_CLR]);
  wire counting = run_q && (per_q != '0) && !restart;
  wire wrap     = counting && (cnt_q == per_q - W'(1));
  wire quiet    = (duty_q == '0) && (per_q == '0);
  wire active   = cnt_q < duty_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart || wrap) begin
      cnt_q <= '0;
    end else if (counting) begin
      cnt_q <= cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= '0;
      per_q  <= '0;
    end else begin
      if (wr_duty) duty_q <= wr_data;
      if (wr_per)  per_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      hiz_q <= 1'b0;
      one_q <= 1'b0;
      ien_q <= 1'b0;
      inv_q <= 1'b0;
    end else if (wr_ctl) begin
      run_q <= wr_data[B_RUN];
      hiz_q <= wr_data[B_HIZ];
      one_q <= wr_data[B_ONE];
      ien_q <= wr_data[B_IEN];
      inv_q <= wr_data[B_INV];
    end else if (wrap && one_q) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         flag_q <= 1'b0;
    else if (wrap)                      flag_q <= 1'b1;
    else if (wr_ctl && wr_data[B_FLG])  flag_q <= 1'b0;
  end

  assign pwm_o    = run_q && !quiet && (active ^ inv_q);
  assign pwm_oe_o = !hiz_q;
  assign irq_o    = flag_q && ien_q;

  always_comb begin
    rd_data = '0;
    case (addr)
      A_DUTY: rd_data = duty_q;
      A_PER:  rd_data = per_q;
      A_CTL: begin
        rd_data[B_RUN] = run_q;
        rd_data[B_HIZ] = hiz_q;
        rd_data[B_ONE] = one_q;
        rd_data[B_IEN] = ien_q;
        rd_data[B_FLG] = flag_q;
        rd_data[B_INV] = inv_q;
      end
      default: rd_data = '0;
    endcase
  end

  // R5
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && !wr_data[B_RUN]) |=> !pwm_o);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) |-> (cnt_q < per_q));

  // R7
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> flag_q);

  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && one_q && !wr_ctl) |=> (!run_q && !pwm_o));

  // R6
  restart_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_duty || wr_per) |=> (cnt_q == '0));

  // R9
  clr_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wr_data[B_CLR]) |=> (cnt_q == '0));
endmodule

// File: tb/regpwm_bench.sv
module regpwm_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_o, pwm_oe_o, irq_o;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  regpwm u_regpwm (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .irq_o(irq_o)
  );

  // behavioural reference
  logic [31:0] m_duty, m_per, m_cnt;
  bit m_run, m_hiz, m_one, m_ien, m_flag, m_inv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_duty = 0; m_per = 0; m_cnt = 0;
      m_run = 0; m_hiz = 0; m_one = 0; m_ien = 0; m_flag = 0; m_inv = 0;
    end else begin
      bit restart, wrapped, ctlw;
      ctlw = wr_en && addr == 4'hC;
      restart = wr_en && (addr == 4'h4 || addr == 4'h8 || (ctlw && wr_data[7]));
      wrapped = 0;
      if (m_run && m_per != 0 && !restart) begin
        if (m_cnt + 1 == m_per) begin
          m_cnt = 0; wrapped = 1; m_flag = 1;
          if (m_one) m_run = 0;
        end else m_cnt = m_cnt + 1;
      end
      if (restart) m_cnt = 0;
      if (wr_en && addr == 4'h4) m_duty = wr_data;
      if (wr_en && addr == 4'h8) m_per = wr_data;
      if (ctlw) begin
        m_run = wr_data[0]; m_hiz = wr_data[3]; m_one = wr_data[4];
        m_ien = wr_data[5]; m_inv = wr_data[9];
        if (wr_data[6] && !wrapped) m_flag = 0;
      end
    end
  end

  function automatic bit m_pwm();
    if (!m_run) return 0;
    if (m_duty == 0 && m_per == 0) return 0;
    return m_inv ? !(m_cnt < m_duty) : (m_cnt < m_duty);
  endfunction

  function automatic logic [31:0] m_rd(logic [3:0] a);
    case (a)
      4'h4: return m_duty;
      4'h8: return m_per;
      4'hC: return {22'd0, m_inv, 2'b00, m_flag, m_ien, m_one, m_hiz, 2'b00, m_run};
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(cur_req, "pwm_o", {31'd0, pwm_o}, {31'd0, m_pwm()});
      chk(cur_req, "pwm_oe_o", {31'd0, pwm_oe_o}, {31'd0, !m_hiz});
      chk(cur_req, "irq_o", {31'd0, irq_o}, {31'd0, m_flag && m_ien});
      chk(cur_req, "rd_data", rd_data, m_rd(addr));
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic look(logic [3:0] a);
    @(posedge clk); #1;
    addr = a;
  endtask

  task automatic count_high(int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o) highs++;
    end
  endtask

  initial begin
    int h;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset pwm_o", {31'd0, pwm_o}, 0);
    chk("R1", "reset pwm_oe_o", {31'd0, pwm_oe_o}, 1);
    chk("R1", "reset irq_o", {31'd0, irq_o}, 0);
    for (int a = 0; a < 16; a++) begin
      addr = a[3:0]; #0.1;
      chk("R1", "reset rd_data", rd_data, 0);
    end
    cmp_on = 1'b1;

    cur_req = "R1";
    wr(4'h4, 32'd3);
    wr(4'h8, 32'd8);
    look(4'h4); @(negedge clk); chk("R1", "duty readback", rd_data, 3);
    look(4'h8); @(negedge clk); chk("R1", "period readback", rd_data, 8);
    look(4'h0); @(negedge clk); chk("R1", "unused offset", rd_data, 0);

    cur_req = "R2";
    wr(4'hC, 32'h1);
    count_high(16, h); chk("R2", "high cycles normal", h, 6);

    cur_req = "R3";
    wr(4'hC, 32'h201);
    count_high(16, h); chk("R3", "high cycles inverted", h, 10);

    cur_req = "R2";
    wr(4'hC, 32'h1);
    wr(4'h4, 32'd9);
    count_high(16, h); chk("R2", "duty above period steady", h, 16);

    cur_req = "R4";
    wr(4'h4, 32'd0);
    wr(4'h8, 32'd0);
    count_high(10, h); chk("R4", "all zero normal", h, 0);
    wr(4'hC, 32'h201);
    count_high(10, h); chk("R4", "all zero inverted", h, 0);

    cur_req = "R11";
    wr(4'hC, 32'h41);
    wr(4'h4, 32'd5);
    count_high(16, h); chk("R11", "zero period steady", h, 16);
    look(4'hC); @(negedge clk); chk("R11", "no flag", {31'd0, rd_data[6]}, 0);

    cur_req = "R5";
    wr(4'h8, 32'd8);
    wr(4'h4, 32'd4);
    wr(4'hC, 32'h201);
    repeat (5) @(posedge clk);
    wr(4'hC, 32'h200);
    count_high(10, h); chk("R5", "stopped inverted low", h, 0);
    wr(4'hC, 32'h001);
    repeat (12) @(posedge clk);

    cur_req = "R6";
    repeat (3) @(posedge clk);
    wr(4'h4, 32'd2);
    count_high(2, h); chk("R6", "restart first cycles", h, 2);
    count_high(6, h); chk("R6", "restart rest of period", h, 0);

    cur_req = "R7";
    look(4'hC);
    for (int k = 0; k < 12; k++) begin
      wr(4'hC, 32'h61);
      repeat (k % 9) @(posedge clk);
    end
    wr(4'hC, 32'h21);
    repeat (9) @(posedge clk);
    @(negedge clk); chk("R7", "irq after wrap", {31'd0, irq_o}, 1);
    wr(4'hC, 32'h01);
    @(negedge clk); chk("R7", "irq masked", {31'd0, irq_o}, 0);
    chk("R7", "flag kept", {31'd0, rd_data[6]}, 1);
    wr(4'h8, 32'd20);
    wr(4'hC, 32'h61);
    @(negedge clk); chk("R7", "flag cleared", {31'd0, rd_data[6]}, 0);

    cur_req = "R8";
    wr(4'h8, 32'd5);
    wr(4'hC, 32'h91);
    count_high(5, h); chk("R8", "single pulse highs", h, 2);
    count_high(10, h); chk("R8", "after single pulse", h, 0);
    chk("R8", "run cleared", {31'd0, rd_data[0]}, 0);

    cur_req = "R9";
    wr(4'hC, 32'h7B9);
    @(negedge clk); chk("R9", "ctrl readback", rd_data & 32'hFFFF_FFBF, 32'h239);
    repeat (7) @(posedge clk);
    wr(4'hC, 32'h081);
    @(negedge clk); chk("R9", "clr reads zero", {31'd0, rd_data[7]}, 0);

    cur_req = "R10";
    wr(4'hC, 32'h009);
    @(negedge clk); chk("R10", "oe off", {31'd0, pwm_oe_o}, 0);
    wr(4'hC, 32'h001);
    @(negedge clk); chk("R10", "oe on", {31'd0, pwm_oe_o}, 1);

    cur_req = "R2";
    wr(4'h8, 32'd3);
    wr(4'h4, 32'd1);
    repeat (20) @(posedge clk);

    @(negedge clk);
    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule